// File: doc/BRIEF.md
# Display Timing Register File

This block is the programmable register bank of a raster display controller. A CPU selects one of 25 byte-wide registers by writing an index port, then reads or writes the selected register through a data port. The block stores the values and protects the horizontal and vertical timing registers from accidental rewrites. It assembles the frame start address and the cursor position from high/low register pairs. It also reports, per category, when a write actually altered configuration bits, so that the downstream timing and memory logic reloads only what moved.

Both CPU ports are plain register accesses that complete in one cycle. They carry no valid/ready handshake and cannot be back-pressured. Reads are combinational from the current index. Writes take effect on the clock edge at which the write strobe is high. Each event output is a single-cycle pulse in the cycle after the write that caused it.

Top module: `disp_timing_regs`

## Requirements
- R1: After reset the index reads 0x00, every data register reads 0x00, protection is off, all event outputs are low and video_off is high.
- R2: The index port stores any 8-bit value written to it, including values above 0x18, and reads it back unchanged.
- R3: A data write while the index is above 0x18 changes no register and raises no event. A data read at such an index returns 0x00.
- R4: While bit 7 of register 0x11 is set, data writes to indices 0x00 through 0x06 are dropped and raise no event. Index 0x08 and above stay writable.
- R5: While bit 7 of register 0x11 is set, a write to register 0x07 replaces only bit 4, and bits 7:5 and 3:0 keep their old values.
- R6: A write that leaves the stored value unchanged raises no event.
- R7: A change to any bit of registers 0x00 to 0x05 pulses ev_width.
- R8: ev_height pulses on a change to register 0x06, 0x10, 0x12, 0x15 or 0x16, to bits 6:0 of register 0x11, to register 0x07 outside bit 4, or to register 0x09 outside bit 6. A change to bit 7 of register 0x11 alone raises nothing.
- R9: ev_line_cmp pulses on a change to register 0x07 bit 4, register 0x09 bit 6 or any bit of register 0x18.
- R10: ev_addr_mode pulses on a change to register 0x13, register 0x14 bit 6 or register 0x17 bit 6. ev_mode_ctl pulses on a change to register 0x17 bits 1:0. A change to register 0x17 bit 7 alone raises no event.
- R11: start_addr equals {reg 0x0C, reg 0x0D} shifted left by addr_shift (0 to 3). A change to register 0x0C or 0x0D pulses ev_mem.
- R12: cursor_loc equals {reg 0x0E, reg 0x0F} shifted left by the same addr_shift. Registers 0x0A, 0x0B, 0x0E, 0x0F and 0x08 raise no event.
- R13: video_off is high exactly when bit 7 of register 0x17 is clear.
- R14: Every event output is high for one cycle, in the cycle after the write edge, and is low again in the following cycle when no new write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr_en | input | 1 | Load the index register |
| idx_wdata | input | 8 | Index value to load |
| idx_rdata | output | 8 | Current index value |
| dat_wr_en | input | 1 | Write the selected data register |
| dat_wdata | input | 8 | Data value to write |
| dat_rdata | output | 8 | Selected register, or 0x00 when the index is out of range |
| addr_shift | input | 2 | Left shift applied to the derived addresses |
| ev_width | output | 1 | Horizontal timing changed pulse |
| ev_height | output | 1 | Vertical timing changed pulse |
| ev_line_cmp | output | 1 | Split-line compare changed pulse |
| ev_addr_mode | output | 1 | Addressing configuration changed pulse |
| ev_mode_ctl | output | 1 | Mode control low bits changed pulse |
| ev_mem | output | 1 | Frame start address changed pulse |
| start_addr | output | 19 | Shifted frame start address |
| cursor_loc | output | 19 | Shifted cursor location |
| video_off | output | 1 | Video output disabled |

## Verification
The hardest state to reach is a protected write to register 0x07. In that state one bit must change, the neighbouring bits must stay frozen, and the event routing must see only the surviving bit. The stimulus first sets several low bits of 0x07 and bit 4 while the register is unprotected, raises the protect flag through register 0x11, and then writes patterns that try to clear or flip every bit. The bench expects the read-back value to hold the old low bits and only a line-compare event, with no height event. The same protected window also covers dropped writes to 0x00 and 0x06, and a write to 0x08 that must still land.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 8;
  localparam int NUM_REGS = 25;
  localparam int SHIFT_W  = 2;

  localparam logic [IDX_W-1:0] IX_H_LAST    = 8'h05;
  localparam logic [IDX_W-1:0] IX_VTOTAL    = 8'h06;
  localparam logic [IDX_W-1:0] IX_OVERFLOW  = 8'h07;
  localparam logic [IDX_W-1:0] IX_CELL      = 8'h09;
  localparam logic [IDX_W-1:0] IX_START_HI  = 8'h0C;
  localparam logic [IDX_W-1:0] IX_START_LO  = 8'h0D;
  localparam logic [IDX_W-1:0] IX_CUR_HI    = 8'h0E;
  localparam logic [IDX_W-1:0] IX_CUR_LO    = 8'h0F;
  localparam logic [IDX_W-1:0] IX_VSYNC_A   = 8'h10;
  localparam logic [IDX_W-1:0] IX_VSYNC_B   = 8'h11;
  localparam logic [IDX_W-1:0] IX_VDISP     = 8'h12;
  localparam logic [IDX_W-1:0] IX_PITCH     = 8'h13;
  localparam logic [IDX_W-1:0] IX_ULINE     = 8'h14;
  localparam logic [IDX_W-1:0] IX_VBLK_A    = 8'h15;
  localparam logic [IDX_W-1:0] IX_VBLK_B    = 8'h16;
  localparam logic [IDX_W-1:0] IX_MODE      = 8'h17;
  localparam logic [IDX_W-1:0] IX_SPLIT     = 8'h18;

  localparam int PROT_BIT   = 7;
  localparam int VID_EN_BIT = 7;
  localparam logic [DATA_W-1:0] OVF_OPEN_MASK = 8'h10;

  typedef enum int {
    EV_WIDTH = 0, EV_HEIGHT = 1, EV_LCMP = 2,
    EV_ADDR = 3, EV_MODE = 4, EV_MEM = 5
  } ev_pos_e;
  localparam int EV_N = 6;
  typedef logic [EV_N-1:0] ev_vec_t;
endpackage

// File: rtl/dtr_wr_guard.sv
module dtr_wr_guard
  import dtr_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cur,
  input  logic              locked,
  output logic              accept,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] flips
);
  localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(NUM_REGS - 1);

  logic in_range, timing_locked;

  always_comb begin
    in_range      = (idx <= LAST_IX);
    timing_locked = locked && (idx <= IX_VTOTAL);
    accept        = in_range && !timing_locked;
    if (locked && idx == IX_OVERFLOW)
      merged = (cur & ~OVF_OPEN_MASK) | (wdata & OVF_OPEN_MASK);
    else
      merged = wdata;
    flips = accept ? (cur ^ merged) : '0;
  end
endmodule

// File: rtl/dtr_evt_route.sv
module dtr_evt_route
  import dtr_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] flips,
  output ev_vec_t           ev
);
  always_comb begin
    ev = '0;
    if (idx <= IX_H_LAST) begin
      ev[EV_WIDTH] = |flips;
    end else begin
      unique case (idx)
        IX_VTOTAL, IX_VSYNC_A, IX_VDISP, IX_VBLK_A, IX_VBLK_B:
          ev[EV_HEIGHT] = |flips;
        IX_OVERFLOW: begin
          ev[EV_HEIGHT] = |(flips & ~OVF_OPEN_MASK);
          ev[EV_LCMP]   = flips[4];
        end
        IX_CELL: begin
          ev[EV_HEIGHT] = |(flips & 8'hBF);
          ev[EV_LCMP]   = flips[6];
        end
        IX_VSYNC_B:
          ev[EV_HEIGHT] = |flips[6:0];
        IX_PITCH:
          ev[EV_ADDR] = |flips;
        IX_ULINE:
          ev[EV_ADDR] = flips[6];
        IX_MODE: begin
          ev[EV_ADDR] = flips[6];
          ev[EV_MODE] = |flips[1:0];
        end
        IX_SPLIT:
          ev[EV_LCMP] = |flips;
        IX_START_HI, IX_START_LO:
          ev[EV_MEM] = |flips;
        default: ev = '0;
      endcase
    end
  end
endmodule

// File: rtl/dtr_addr_join.sv
module dtr_addr_join #(
  parameter int BYTE_W  = 8,
  parameter int SHIFT_W = 2,
  localparam int OUT_W  = 2 * BYTE_W + (1 << SHIFT_W) - 1
) (
  input  logic [BYTE_W-1:0]  hi,
  input  logic [BYTE_W-1:0]  lo,
  input  logic [SHIFT_W-1:0] shift,
  output logic [OUT_W-1:0]   addr
);
  logic [OUT_W-1:0] base;
  always_comb begin
    base = OUT_W'({hi, lo});
    addr = base << shift;
  end
endmodule

// File: rtl/disp_timing_regs.sv
module disp_timing_regs
  import dtr_pkg::*;
#(
  localparam int ADDR_W = 2 * DATA_W + (1 << SHIFT_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_wr_en,
  input  logic [IDX_W-1:0]   idx_wdata,
  output logic [IDX_W-1:0]   idx_rdata,
  input  logic               dat_wr_en,
  input  logic [DATA_W-1:0]  dat_wdata,
  output logic [DATA_W-1:0]  dat_rdata,
  input  logic [SHIFT_W-1:0] addr_shift,
  output logic               ev_width,
  output logic               ev_height,
  output logic               ev_line_cmp,
  output logic               ev_addr_mode,
  output logic               ev_mode_ctl,
  output logic               ev_mem,
  output logic [ADDR_W-1:0]  start_addr,
  output logic [ADDR_W-1:0]  cursor_loc,
  output logic               video_off
);
  localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(NUM_REGS - 1);
  localparam int NUM_PAIRS = 2;

  logic [IDX_W-1:0]  index_q;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] cur_val;
  logic              protect;
  logic              accept;
  logic [DATA_W-1:0] merged, flips;
  ev_vec_t           ev_next, ev_q;

  // index register
  always_ff @(posedge clk) begin
    if (!rst_n)         index_q <= '0;
    else if (idx_wr_en) index_q <= idx_wdata;
  end
  assign idx_rdata = index_q;

  // selected register value
  always_comb begin
    cur_val = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (index_q == IDX_W'(k)) cur_val = regs[k];
  end
  assign dat_rdata = cur_val;
  assign protect   = regs[IX_VSYNC_B][PROT_BIT];

  dtr_wr_guard u_guard (
    .idx    (index_q),
    .wdata  (dat_wdata),
    .cur    (cur_val),
    .locked (protect),
    .accept (accept),
    .merged (merged),
    .flips  (flips)
  );

  dtr_evt_route u_route (
    .idx   (index_q),
    .flips (flips),
    .ev    (ev_next)
  );

  // storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= '0;
    end else if (dat_wr_en && accept && (|flips)) begin
      for (int k = 0; k < NUM_REGS; k++)
        if (index_q == IDX_W'(k)) regs[k] <= merged;
    end
  end

  // event pulses
  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= dat_wr_en ? ev_next : '0;
  end

  assign ev_width     = ev_q[EV_WIDTH];
  assign ev_height    = ev_q[EV_HEIGHT];
  assign ev_line_cmp  = ev_q[EV_LCMP];
  assign ev_addr_mode = ev_q[EV_ADDR];
  assign ev_mode_ctl  = ev_q[EV_MODE];
  assign ev_mem       = ev_q[EV_MEM];

  assign video_off = ~regs[IX_MODE][VID_EN_BIT];

  // derived addresses
  logic [DATA_W-1:0] pair_hi  [NUM_PAIRS];
  logic [DATA_W-1:0] pair_lo  [NUM_PAIRS];
  logic [ADDR_W-1:0] pair_out [NUM_PAIRS];

  assign pair_hi[0] = regs[IX_START_HI];
  assign pair_lo[0] = regs[IX_START_LO];
  assign pair_hi[1] = regs[IX_CUR_HI];
  assign pair_lo[1] = regs[IX_CUR_LO];

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    dtr_addr_join #(.BYTE_W(DATA_W), .SHIFT_W(SHIFT_W)) u_join (
      .hi    (pair_hi[g]),
      .lo    (pair_lo[g]),
      .shift (addr_shift),
      .addr  (pair_out[g])
    );
  end

  assign start_addr = pair_out[0];
  assign cursor_loc = pair_out[1];

  // assertions
  AST_PROT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_en && protect && index_q <= IX_VTOTAL) |=> (!ev_width && !ev_height)); // R4

  AST_OVF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_en && protect && index_q == IX_OVERFLOW)
      |=> ((regs[IX_OVERFLOW] & 8'hEF) == $past(regs[IX_OVERFLOW] & 8'hEF))); // R5

  AST_OOR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_en && index_q > LAST_IX) |=> (ev_q == '0)); // R3

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (index_q > LAST_IX) |-> (dat_rdata == '0)); // R3

  AST_EVT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_q) |-> $past(dat_wr_en)); // R14

  AST_VOFF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (video_off != $past(video_off)) |-> $past(dat_wr_en)); // R13

  AST_MEM_PAIR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem |-> ($past(index_q) == IX_START_HI || $past(index_q) == IX_START_LO)); // R11
endmodule

// File: tb/sim_disp_timing_regs.sv
module sim_disp_timing_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr_en = 1'b0;
  logic [7:0]  idx_wdata = '0;
  logic [7:0]  idx_rdata;
  logic        dat_wr_en = 1'b0;
  logic [7:0]  dat_wdata = '0;
  logic [7:0]  dat_rdata;
  logic [1:0]  addr_shift = '0;
  logic        ev_width, ev_height, ev_line_cmp, ev_addr_mode, ev_mode_ctl, ev_mem;
  logic [18:0] start_addr, cursor_loc;
  logic        video_off;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disp_timing_regs u0 (
    .clk(clk), .rst_n(rst_n),
    .idx_wr_en(idx_wr_en), .idx_wdata(idx_wdata), .idx_rdata(idx_rdata),
    .dat_wr_en(dat_wr_en), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .addr_shift(addr_shift),
    .ev_width(ev_width), .ev_height(ev_height), .ev_line_cmp(ev_line_cmp),
    .ev_addr_mode(ev_addr_mode), .ev_mode_ctl(ev_mode_ctl), .ev_mem(ev_mem),
    .start_addr(start_addr), .cursor_loc(cursor_loc), .video_off(video_off)
  );

  // event bits: 0 width, 1 height, 2 line compare, 3 addr mode, 4 mode ctl, 5 mem
  function automatic logic [5:0] evs();
    return {ev_mem, ev_mode_ctl, ev_addr_mode, ev_line_cmp, ev_height, ev_width};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] ix);
    @(negedge clk);
    idx_wr_en = 1'b1; idx_wdata = ix;
    @(negedge clk);
    idx_wr_en = 1'b0;
  endtask

  // writes data at the selected index; returns at the negedge where events are visible
  task automatic wr(input logic [7:0] ix, input logic [7:0] d);
    set_idx(ix);
    dat_wr_en = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_wr_en = 1'b0;
  endtask

  localparam int NV = 31;
  // {index, data, expected events, expected read-back}
  localparam logic [29:0] VEC [NV] = '{
    {8'h00, 8'h5F, 6'h01, 8'h5F},  // R7
    {8'h05, 8'h81, 6'h01, 8'h81},  // R7
    {8'h05, 8'h81, 6'h00, 8'h81},  // R6 no change
    {8'h06, 8'hBF, 6'h02, 8'hBF},  // R8
    {8'h07, 8'h1F, 6'h06, 8'h1F},  // R8 R9
    {8'h09, 8'h40, 6'h04, 8'h40},  // R9
    {8'h09, 8'h4F, 6'h02, 8'h4F},  // R8
    {8'h10, 8'h9C, 6'h02, 8'h9C},  // R8
    {8'h12, 8'h8F, 6'h02, 8'h8F},  // R8
    {8'h15, 8'h96, 6'h02, 8'h96},  // R8
    {8'h16, 8'hB9, 6'h02, 8'hB9},  // R8
    {8'h13, 8'h28, 6'h08, 8'h28},  // R10
    {8'h14, 8'h1F, 6'h00, 8'h1F},  // R10 bit 6 untouched
    {8'h14, 8'h5F, 6'h08, 8'h5F},  // R10
    {8'h17, 8'h03, 6'h10, 8'h03},  // R10
    {8'h17, 8'hC3, 6'h08, 8'hC3},  // R10 bit 7 raises nothing
    {8'h18, 8'hFF, 6'h04, 8'hFF},  // R9
    {8'h0C, 8'h12, 6'h20, 8'h12},  // R11
    {8'h0D, 8'h34, 6'h20, 8'h34},  // R11
    {8'h0E, 8'h05, 6'h00, 8'h05},  // R12
    {8'h0F, 8'h50, 6'h00, 8'h50},  // R12
    {8'h0A, 8'h0D, 6'h00, 8'h0D},  // R12
    {8'h11, 8'h0E, 6'h02, 8'h0E},  // R8
    {8'h11, 8'h8E, 6'h00, 8'h8E},  // R8 protect bit alone
    {8'h00, 8'h00, 6'h00, 8'h5F},  // R4 dropped
    {8'h06, 8'h00, 6'h00, 8'hBF},  // R4 dropped
    {8'h07, 8'h00, 6'h04, 8'h0F},  // R5 only bit 4
    {8'h07, 8'hF0, 6'h04, 8'h1F},  // R5 only bit 4
    {8'h08, 8'h02, 6'h00, 8'h02},  // R4 0x08 writable, R12 no event
    {8'h11, 8'h0E, 6'h00, 8'h0E},  // R4 unlock
    {8'h00, 8'h2D, 6'h01, 8'h2D}   // R7 after unlock
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 index", 32'(idx_rdata), 32'h00);
    chk("R1 events", 32'(evs()), 32'h00);
    chk("R1 video_off", 32'(video_off), 32'h1);
    chk("R1 start_addr", 32'(start_addr), 32'h0);
    for (int i = 0; i < 25; i++) begin
      set_idx(8'(i));
      chk("R1 register zero", 32'(dat_rdata), 32'h00);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] ix, d, rb;
      logic [5:0] ev;
      {ix, d, ev, rb} = VEC[i];
      wr(ix, d);
      chk($sformatf("R6..R14 row %0d events", i), 32'(evs()), 32'(ev));
      chk($sformatf("R4/R5 row %0d readback", i), 32'(dat_rdata), 32'(rb));
      @(negedge clk);
      chk($sformatf("R14 row %0d pulse ends", i), 32'(evs()), 32'h00);
    end

    // R2 index readback of large values
    set_idx(8'hFF);
    chk("R2 index 0xFF", 32'(idx_rdata), 32'hFF);
    chk("R3 read out of range", 32'(dat_rdata), 32'h00);
    set_idx(8'h19);
    chk("R2 index 0x19", 32'(idx_rdata), 32'h19);

    // R3 out-of-range writes
    wr(8'h19, 8'hAA);
    chk("R3 no event", 32'(evs()), 32'h00);
    chk("R3 read 0x19", 32'(dat_rdata), 32'h00);
    wr(8'hFF, 8'h55);
    chk("R3 no event 0xFF", 32'(evs()), 32'h00);
    set_idx(8'h18);
    chk("R3 0x18 intact", 32'(dat_rdata), 32'hFF);
    set_idx(8'h00);
    chk("R3 0x00 intact", 32'(dat_rdata), 32'h2D);

    // R11 / R12 derived addresses across shifts
    for (int s = 0; s < 4; s++) begin
      addr_shift = 2'(s);
      #1;
      chk("R11 start_addr", 32'(start_addr), 32'h1234 << s);
      chk("R12 cursor_loc", 32'(cursor_loc), 32'h0550 << s);
    end
    addr_shift = 2'd0;

    // R13 video off follows mode bit 7
    chk("R13 video on", 32'(video_off), 32'h0);
    wr(8'h17, 8'h43);
    chk("R13 video off", 32'(video_off), 32'h1);
    chk("R10 bit 7 no event", 32'(evs()), 32'h00);
    wr(8'h17, 8'hC3);
    chk("R13 video on again", 32'(video_off), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule